// File: doc/BRIEF.md
# Banked Data-Memory Address Generator

This block forms the 9-bit data-memory address for an 8-bit microcontroller core and drives the strobes of a dual-port data RAM. Each operand access gives a 7-bit file field taken from the instruction. If that field selects any location other than offset zero, the address is direct: the two page-select bits sit above the 7-bit field. If the field is zero, the instruction names the indirect-access register, and the address is the single indirect page bit placed above the 8-bit pointer value.

Reads are issued in the operand cycle. The RAM returns data one cycle later, and the write-back of the ALU result also lands one cycle later, at the address captured in the operand cycle. So a read of the current instruction and a write of the previous one can go to different addresses in the same cycle. An indirect access whose pointer selects the indirect register itself (pointer offset bits zero) is handled specially. No RAM read is issued and the operand returned is 0x00. A write-back for that access is dropped silently, with no stall.

Top module: `data_addr_gen`

## Requirements
- R1: When `op_valid_i` is high and `op_file_i` is non-zero, `ram_raddr_o` equals `{page_sel_i, op_file_i}` (page bits in [8:7], file field in [6:0]) in the same cycle.
- R2: When `op_valid_i` is high and `op_file_i` is zero, `ram_raddr_o` equals `{ind_page_i, ptr_i}` (indirect page bit in [8], pointer in [7:0]) in the same cycle.
- R3: `ram_oe_o` is high exactly when `op_valid_i` is high and the access is not a self-reference. It is low whenever `op_valid_i` is low.
- R4: A self-reference is an access with `op_file_i` zero and `ptr_i[6:0]` zero, whatever `ptr_i[7]` and `ind_page_i` are. In the cycle after such an access, `opnd_o` is 0x00 whatever `ram_rdata_i` carries, and `ram_oe_o` is low during the access.
- R5: In the cycle after a non-self-reference access, `ram_we_o` equals `res_we_i`, and `ram_waddr_o` equals the address that access presented on `ram_raddr_o`.
- R6: In the cycle after a self-reference access, `ram_we_o` stays low even when `res_we_i` is high.
- R7: In the cycle after a non-self-reference access, `opnd_o` equals `ram_rdata_i`.
- R8: With back-to-back accesses, one cycle carries the read address of the current access on `ram_raddr_o` and the write address of the previous access on `ram_waddr_o`, and the two may differ.
- R9: After reset, and in any cycle not preceded by an access, `ram_we_o` is low even when `res_we_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Operand access in this cycle |
| op_file_i | input | 7 | File field of the instruction |
| page_sel_i | input | 2 | Page bits for direct addressing |
| ind_page_i | input | 1 | Page bit for indirect addressing |
| ptr_i | input | 8 | Pointer register value |
| res_we_i | input | 1 | ALU result is to be written back this cycle |
| ram_rdata_i | input | 8 | RAM read data, one cycle after the read |
| ram_raddr_o | output | 9 | RAM read address |
| ram_oe_o | output | 1 | RAM output enable |
| ram_waddr_o | output | 9 | RAM write address |
| ram_we_o | output | 1 | RAM write enable pulse |
| opnd_o | output | 8 | Operand delivered to the ALU |

## Verification
Direct accesses are run in several pages with distinct file fields, so that a swapped or shifted page field shows up in the address. Indirect accesses are run with pointers whose low seven bits are non-zero and whose top bit and page bit vary, so that they cannot be mistaken for direct or self-reference cases. Self-references are run with both values of the pointer top bit and the page bit, and with non-zero RAM data and an active write request, so that a dropped-read or dropped-write failure is visible. Back-to-back accesses to different addresses separate the read and write buses, and a write request with no preceding access checks that no write is issued.

// File: rtl/dag_pkg.sv
package dag_pkg;
  // Classification of an operand access
  typedef enum logic [1:0] {
    ACC_NONE     = 2'd0,
    ACC_DIRECT   = 2'd1,
    ACC_INDIRECT = 2'd2,
    ACC_SELF     = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/dag_addr_mux.sv
module dag_addr_mux
  import dag_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int OFS_W  = 7,
  parameter int PTR_W  = 8
) (
  input  logic                      valid_i,
  input  logic [OFS_W-1:0]          file_i,
  input  logic [ADDR_W-OFS_W-1:0]   page_i,
  input  logic [ADDR_W-PTR_W-1:0]   ind_page_i,
  input  logic [PTR_W-1:0]          ptr_i,
  output logic [ADDR_W-1:0]         addr_o,
  output acc_kind_e                 kind_o
);
  localparam int PAGE_W  = ADDR_W - OFS_W;
  localparam int IPAGE_W = ADDR_W - PTR_W;

  function automatic logic [ADDR_W-1:0] direct_addr(
    input logic [PAGE_W-1:0] pg, input logic [OFS_W-1:0] fl);
    return {pg, fl};
  endfunction

  function automatic logic [ADDR_W-1:0] indirect_addr(
    input logic [IPAGE_W-1:0] pg, input logic [PTR_W-1:0] p);
    return {pg, p};
  endfunction

  function automatic logic names_ind_reg(input logic [OFS_W-1:0] ofs);
    return ofs == '0;
  endfunction

  logic is_ind;
  logic is_self;

  always_comb begin
    is_ind  = names_ind_reg(file_i);
    is_self = is_ind && names_ind_reg(ptr_i[OFS_W-1:0]);
    addr_o  = is_ind ? indirect_addr(ind_page_i, ptr_i)
                     : direct_addr(page_i, file_i);
    if (!valid_i)     kind_o = ACC_NONE;
    else if (is_self) kind_o = ACC_SELF;
    else if (is_ind)  kind_o = ACC_INDIRECT;
    else              kind_o = ACC_DIRECT;
  end
endmodule

// File: rtl/dag_wb_stage.sv
module dag_wb_stage
  import dag_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              res_we_i,
  output acc_kind_e         kind_q_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic              we_o
);
  acc_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= ACC_NONE;
      addr_q <= '0;
    end else begin
      kind_q <= kind_i;
      if (kind_i != ACC_NONE) addr_q <= addr_i;
    end
  end

  assign kind_q_o = kind_q;
  assign waddr_o  = addr_q;
  assign we_o     = res_we_i &&
                    (kind_q == ACC_DIRECT || kind_q == ACC_INDIRECT);
endmodule

// File: rtl/dag_rdata_guard.sv
module dag_rdata_guard
  import dag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  acc_kind_e         kind_q_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] opnd_o
);
  assign opnd_o = (kind_q_i == ACC_SELF) ? '0 : rdata_i;
endmodule

// File: rtl/data_addr_gen.sv
module data_addr_gen
  import dag_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int OFS_W  = 7,
  parameter int PTR_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_valid_i,
  input  logic [OFS_W-1:0]        op_file_i,
  input  logic [ADDR_W-OFS_W-1:0] page_sel_i,
  input  logic [ADDR_W-PTR_W-1:0] ind_page_i,
  input  logic [PTR_W-1:0]        ptr_i,
  input  logic                    res_we_i,
  input  logic [DATA_W-1:0]       ram_rdata_i,
  output logic [ADDR_W-1:0]       ram_raddr_o,
  output logic                    ram_oe_o,
  output logic [ADDR_W-1:0]       ram_waddr_o,
  output logic                    ram_we_o,
  output logic [DATA_W-1:0]       opnd_o
);
  // Named internal events, visible to the checker
  acc_kind_e kind_w;
  acc_kind_e kind_q_w;

  dag_addr_mux #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .PTR_W(PTR_W)) u_mux (
    .valid_i    (op_valid_i),
    .file_i     (op_file_i),
    .page_i     (page_sel_i),
    .ind_page_i (ind_page_i),
    .ptr_i      (ptr_i),
    .addr_o     (ram_raddr_o),
    .kind_o     (kind_w)
  );

  assign ram_oe_o = (kind_w == ACC_DIRECT) || (kind_w == ACC_INDIRECT);

  dag_wb_stage #(.ADDR_W(ADDR_W)) u_wb (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind_i   (kind_w),
    .addr_i   (ram_raddr_o),
    .res_we_i (res_we_i),
    .kind_q_o (kind_q_w),
    .waddr_o  (ram_waddr_o),
    .we_o     (ram_we_o)
  );

  dag_rdata_guard #(.DATA_W(DATA_W)) u_guard (
    .kind_q_i (kind_q_w),
    .rdata_i  (ram_rdata_i),
    .opnd_o   (opnd_o)
  );
endmodule

// File: rtl/data_addr_gen_chk.sv
module data_addr_gen_chk #(
  parameter int ADDR_W = 9,
  parameter int OFS_W  = 7,
  parameter int PTR_W  = 8,
  parameter int DATA_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    op_valid_i,
  input logic [OFS_W-1:0]        op_file_i,
  input logic [ADDR_W-OFS_W-1:0] page_sel_i,
  input logic [ADDR_W-PTR_W-1:0] ind_page_i,
  input logic [PTR_W-1:0]        ptr_i,
  input logic                    res_we_i,
  input logic [DATA_W-1:0]       ram_rdata_i,
  input logic [ADDR_W-1:0]       ram_raddr_o,
  input logic                    ram_oe_o,
  input logic [ADDR_W-1:0]       ram_waddr_o,
  input logic                    ram_we_o,
  input logic [DATA_W-1:0]       opnd_o
);
  logic self_acc;
  assign self_acc = op_valid_i && (op_file_i == '0) && (ptr_i[OFS_W-1:0] == '0);

  assert_direct_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_file_i != '0) |-> ram_raddr_o == {page_sel_i, op_file_i});

  assert_indirect_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_file_i == '0) |-> ram_raddr_o == {ind_page_i, ptr_i});

  assert_oe_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |-> !ram_oe_o);

  assert_oe_self_R4: assert property (@(posedge clk) disable iff (!rst_n)
    self_acc |-> !ram_oe_o);

  assert_self_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    self_acc |=> opnd_o == '0);

  assert_waddr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> (ram_waddr_o == $past(ram_raddr_o)) && $past(ram_oe_o));

  assert_self_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    self_acc |=> !ram_we_o);

  assert_pass_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_oe_o |=> opnd_o == ram_rdata_i);

  assert_we_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> res_we_i);
endmodule

bind data_addr_gen data_addr_gen_chk #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .PTR_W(PTR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_file_i(op_file_i),
  .page_sel_i(page_sel_i), .ind_page_i(ind_page_i), .ptr_i(ptr_i),
  .res_we_i(res_we_i), .ram_rdata_i(ram_rdata_i), .ram_raddr_o(ram_raddr_o),
  .ram_oe_o(ram_oe_o), .ram_waddr_o(ram_waddr_o), .ram_we_o(ram_we_o),
  .opnd_o(opnd_o)
);

// File: tb/test_data_addr_gen.sv
`timescale 1ns/1ps
module test_data_addr_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid_i = 1'b0;
  logic [6:0] op_file_i = '0;
  logic [1:0] page_sel_i = '0;
  logic       ind_page_i = 1'b0;
  logic [7:0] ptr_i = '0;
  logic       res_we_i = 1'b0;
  logic [7:0] ram_rdata_i = '0;
  logic [8:0] ram_raddr_o;
  logic       ram_oe_o;
  logic [8:0] ram_waddr_o;
  logic       ram_we_o;
  logic [7:0] opnd_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  data_addr_gen i_data_addr_gen (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_file_i(op_file_i),
    .page_sel_i(page_sel_i), .ind_page_i(ind_page_i), .ptr_i(ptr_i),
    .res_we_i(res_we_i), .ram_rdata_i(ram_rdata_i), .ram_raddr_o(ram_raddr_o),
    .ram_oe_o(ram_oe_o), .ram_waddr_o(ram_waddr_o), .ram_we_o(ram_we_o),
    .opnd_o(opnd_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected address computed arithmetically from the requirements
  function automatic int exp_addr(int file, int pg, int ipg, int p);
    if (file == 0) return ipg * 256 + p;
    return pg * 128 + file;
  endfunction

  function automatic bit exp_self(int file, int p);
    return (file == 0) && ((p % 128) == 0);
  endfunction

  // One access followed by its write-back cycle
  task automatic access(input string tag, input int file, input int pg,
                        input int ipg, input int p, input int rdat);
    int a;
    bit s;
    a = exp_addr(file, pg, ipg, p);
    s = exp_self(file, p);
    @(negedge clk);
    op_valid_i = 1'b1; op_file_i = 7'(file); page_sel_i = 2'(pg);
    ind_page_i = 1'(ipg); ptr_i = 8'(p); res_we_i = 1'b0;
    #1;
    check({tag, " raddr R1/R2"}, int'(ram_raddr_o), a);
    check({tag, " oe R3"}, int'(ram_oe_o), s ? 0 : 1);
    @(negedge clk);
    op_valid_i = 1'b0; res_we_i = 1'b1; ram_rdata_i = 8'(rdat);
    #1;
    if (s) begin
      check({tag, " self operand R4"}, int'(opnd_o), 0);
      check({tag, " self write dropped R6"}, int'(ram_we_o), 0);
    end else begin
      check({tag, " operand R7"}, int'(opnd_o), rdat);
      check({tag, " we R5"}, int'(ram_we_o), 1);
      check({tag, " waddr R5"}, int'(ram_waddr_o), a);
    end
    check({tag, " oe idle R3"}, int'(ram_oe_o), 0);
    res_we_i = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    res_we_i = 1'b1;
    #1;
    check("reset we R9", int'(ram_we_o), 0);
    check("reset oe R3", int'(ram_oe_o), 0);
    res_we_i = 1'b0;
  endtask

  task automatic t_direct;
    access("direct p0", 7'h05, 0, 1, 8'h80, 8'h11);
    access("direct p2", 7'h7F, 2, 0, 8'h00, 8'h22);
    access("direct p3", 7'h2A, 3, 1, 8'h00, 8'h33);
    access("direct p1", 7'h01, 1, 0, 8'h55, 8'h44);
  endtask

  task automatic t_indirect;
    access("indirect lo", 0, 3, 0, 8'h3C, 8'h5A);
    access("indirect hi", 0, 0, 1, 8'hC1, 8'hA5);
    access("indirect ff", 0, 2, 1, 8'hFF, 8'h0F);
  endtask

  task automatic t_self;
    access("self 00", 0, 1, 0, 8'h00, 8'hEE);
    access("self 80", 0, 2, 1, 8'h80, 8'h77);
    access("self 100", 0, 0, 1, 8'h00, 8'hFF);
  endtask

  // R8: back-to-back accesses, read and write buses differ in one cycle
  task automatic t_back_to_back;
    @(negedge clk);
    op_valid_i = 1'b1; op_file_i = 7'h10; page_sel_i = 2'd1; res_we_i = 1'b0;
    @(negedge clk);
    op_file_i = 7'h20; page_sel_i = 2'd2; res_we_i = 1'b1; ram_rdata_i = 8'h99;
    #1;
    check("b2b raddr R8", int'(ram_raddr_o), 2 * 128 + 32);
    check("b2b waddr R8", int'(ram_waddr_o), 128 + 16);
    check("b2b we R8", int'(ram_we_o), 1);
    @(negedge clk);
    op_valid_i = 1'b0; res_we_i = 1'b1;
    #1;
    check("b2b second waddr R8", int'(ram_waddr_o), 2 * 128 + 32);
    @(negedge clk);
    #1;
    check("no pending access we R9", int'(ram_we_o), 0);
    res_we_i = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1;
    check("reset held we R9", int'(ram_we_o), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct();
    t_indirect();
    t_self();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule